// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the command side of an I2C master controller. Software-style command words of 11 bits enter a command FIFO through a valid/ready write port. Each word either carries one byte to transmit or asks for one byte to be received. Two flag bits ride along with it: one asks for a STOP after the byte, and one asks for a repeated START before it. The sequencer takes words out in order and hands each one, as a single byte-level request, to a bit-level engine. The engine performs the SCL/SDA timing and answers with a one-cycle acknowledge. Bytes read from the bus go into a separate receive FIFO, which is drained through a valid/ready read port.

Back-pressure works as follows. `cmd_ready` is high while the command FIFO has room and no abort is present. A word offered while the FIFO is full is discarded, and the drop is reported. `rx_valid` is high while a received byte is waiting, and `rx_data` always shows the oldest byte. Asserting `rx_ready` removes that byte. Asserting `rx_ready` with nothing waiting reads zero and is reported.

Both FIFO fill levels are visible. Each FIFO has its own programmable threshold flag. An abort input empties both FIFOs and cancels any request still outstanding at the engine. When the command FIFO runs dry and no STOP has been sent, the sequencer keeps the bus claimed and waits for more words.

Top module: `i2cseq_top`

## Requirements
- R1: A word offered with `cmd_valid` while `cmd_ready` is high is stored. Words reach the engine in the order they were written.
- R2: A word with bit 8 clear is a transmit. The engine sees `eng_rd`=0 and `eng_wdata` equal to word bits 7:0. The request and its fields stay unchanged until `eng_ack`.
- R3: A word with bit 8 set is a receive. The engine sees `eng_rd`=1 and `eng_wdata`=0, whatever bits 7:0 hold. On `eng_ack`, the byte on `eng_rdata` is placed in the receive FIFO.
- R4: Bit 9 of a word drives `eng_stop` with that byte. Once that byte is acknowledged, the bus is released (`bus_hold`=0).
- R5: Bit 10 of a word drives `eng_rstart` with that byte.
- R6: `tx_level` and `rx_level` give the current number of entries in the command FIFO and the receive FIFO.
- R7: `tx_below_thr` is high exactly when `tx_level` <= `tx_thresh`.
- R8: `rx_above_thr` is high exactly when `rx_level` > `rx_thresh`.
- R9: A word offered while the command FIFO is full is dropped and leaves `tx_level` unchanged. `tx_over` pulses for one cycle after the edge that dropped it.
- R10: With the receive FIFO empty, `rx_data` reads 0 and `rx_valid` is 0. A read attempt then pulses `rx_under` for one cycle after the edge.
- R11: `abort` empties both FIFOs at the next edge and withdraws any outstanding engine request. An `eng_ack` that arrives later has no effect.
- R12: When the command FIFO is empty after a byte without STOP, `bus_hold` is high and no request is issued.
- R13: A receive word is not issued while the receive FIFO is full. It is issued once a byte has been read out.
- R14: `rx_data` returns received bytes in arrival order, one per accepted `rx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command FIFO can take a word |
| cmd_data | input | 11 | Command word: [10] restart, [9] stop, [8] read, [7:0] byte |
| rx_valid | output | 1 | A received byte is waiting |
| rx_ready | input | 1 | Consume the waiting byte |
| rx_data | output | 8 | Oldest received byte, 0 when empty |
| tx_thresh | input | TX_LW | Command FIFO threshold |
| rx_thresh | input | RX_LW | Receive FIFO threshold |
| tx_level | output | TX_LW | Command FIFO fill level |
| rx_level | output | RX_LW | Receive FIFO fill level |
| tx_below_thr | output | 1 | tx_level <= tx_thresh |
| rx_above_thr | output | 1 | rx_level > rx_thresh |
| tx_over | output | 1 | One-cycle pulse: write dropped |
| rx_under | output | 1 | One-cycle pulse: read of empty FIFO |
| abort | input | 1 | Flush both FIFOs, cancel request |
| eng_req | output | 1 | Byte request to the engine |
| eng_rd | output | 1 | Request is a receive |
| eng_wdata | output | 8 | Byte to transmit |
| eng_stop | output | 1 | STOP after this byte |
| eng_rstart | output | 1 | Repeated START before this byte |
| eng_ack | input | 1 | Engine finished the byte |
| eng_rdata | input | 8 | Received byte, valid with eng_ack |
| bus_hold | output | 1 | Bus claimed, waiting for commands |

TX_LW and RX_LW are clog2(depth+1), which is 4 for the default depth of 8.

## Verification
A command word takes two rising edges to reach the engine: the first edge stores it in the FIFO, and the second loads it into the sequencer and raises `eng_req`. Fill levels, threshold flags and the `tx_over`/`rx_under` pulses settle one edge after their cause. A received byte becomes visible on `rx_data` one edge after `eng_ack`. The bench drives every input and samples every output at falling edges. After each stimulus edge it counts those edge delays before it compares, so each value is read in the cycle it becomes due and not one cycle off.

// File: rtl/i2cseq_pkg.sv
`timescale 1ns/1ps
package i2cseq_pkg;
  // Command word layout: the field order is what decoders depend on.
  typedef struct packed {
    logic       rstart;  // [10] repeated START before byte
    logic       stop;    // [9]  STOP after byte
    logic       rd;      // [8]  receive one byte
    logic [7:0] dat;     // [7:0] transmit byte
  } cmd_word_t;

  localparam int CMD_W = $bits(cmd_word_t);

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_BUSY = 1'b1
  } sq_state_e;
endpackage

// File: rtl/i2cseq_fifo.sv
`timescale 1ns/1ps
module i2cseq_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [LW-1:0]    level,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [LW-1:0]    count;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= ptr_inc(wr_ptr);
      if (rd_en) rd_ptr <= ptr_inc(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + LW'(1);
        2'b01:   count <= count - LW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
  assign level   = count;
  assign full    = (count == LW'(DEPTH));
  assign empty   = (count == '0);

  // The surrounding logic must never push into a full FIFO (R9).
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  // The surrounding logic must never pop an empty FIFO (R10).
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty);
  // The level never exceeds the depth (R6).
  p_level_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LW'(DEPTH));
endmodule

// File: rtl/i2cseq_issue.sv
`timescale 1ns/1ps
module i2cseq_issue
  import i2cseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      abort,
  input  cmd_word_t cmd_head,
  input  logic      cmd_empty,
  output logic      cmd_pop,
  input  logic      rx_full,
  output logic      rx_push,
  output logic      eng_req,
  output logic      eng_rd,
  output logic [7:0] eng_wdata,
  output logic      eng_stop,
  output logic      eng_rstart,
  input  logic      eng_ack,
  output logic      bus_hold
);
  sq_state_e state;
  cmd_word_t cur;
  logic      bus_active;
  logic      launch;

  // A receive waits for room so its byte can always be stored (R13).
  assign launch  = (state == SQ_IDLE) && !cmd_empty && !abort &&
                   !(cmd_head.rd && rx_full);
  assign cmd_pop = launch;
  assign rx_push = (state == SQ_BUSY) && eng_ack && cur.rd && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      cur        <= '0;
      bus_active <= 1'b0;
    end else if (abort) begin
      state      <= SQ_IDLE;
      bus_active <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: if (launch) begin
          state      <= SQ_BUSY;
          bus_active <= 1'b1;
          cur.rstart <= cmd_head.rstart;
          cur.stop   <= cmd_head.stop;
          cur.rd     <= cmd_head.rd;
          cur.dat    <= cmd_head.rd ? 8'h00 : cmd_head.dat;
        end
        SQ_BUSY: if (eng_ack) begin
          state <= SQ_IDLE;
          if (cur.stop) bus_active <= 1'b0;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign eng_req    = (state == SQ_BUSY);
  assign eng_rd     = cur.rd;
  assign eng_wdata  = cur.dat;
  assign eng_stop   = cur.stop;
  assign eng_rstart = cur.rstart;
  assign bus_hold   = bus_active && (state == SQ_IDLE) && cmd_empty;

  // An outstanding request and its fields hold until acknowledged (R2).
  p_req_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_ack && !abort |=>
      eng_req && $stable({eng_rd, eng_wdata, eng_stop, eng_rstart}));
  // A STOP byte acknowledged releases the bus (R4).
  p_stop_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_ack && eng_stop && !abort |=> !bus_hold);
  // Received bytes only arrive when the receive FIFO has room (R13).
  p_read_room_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);
endmodule

// File: rtl/i2cseq_flags.sv
`timescale 1ns/1ps
module i2cseq_flags #(
  parameter int TX_LW = 4,
  parameter int RX_LW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TX_LW-1:0] tx_level,
  input  logic [TX_LW-1:0] tx_thresh,
  input  logic [RX_LW-1:0] rx_level,
  input  logic [RX_LW-1:0] rx_thresh,
  input  logic             wr_drop,
  input  logic             rd_drop,
  output logic             tx_below_thr,
  output logic             rx_above_thr,
  output logic             tx_over,
  output logic             rx_under
);
  assign tx_below_thr = (tx_level <= tx_thresh);
  assign rx_above_thr = (rx_level >  rx_thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_over  <= 1'b0;
      rx_under <= 1'b0;
    end else begin
      tx_over  <= wr_drop;
      rx_under <= rd_drop;
    end
  end
endmodule

// File: rtl/i2cseq_top.sv
`timescale 1ns/1ps
module i2cseq_top
  import i2cseq_pkg::*;
#(
  parameter int  TX_DEPTH = 8,
  parameter int  RX_DEPTH = 8,
  localparam int TX_LW    = $clog2(TX_DEPTH + 1),
  localparam int RX_LW    = $clog2(RX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [10:0]      cmd_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  input  logic [TX_LW-1:0] tx_thresh,
  input  logic [RX_LW-1:0] rx_thresh,
  output logic [TX_LW-1:0] tx_level,
  output logic [RX_LW-1:0] rx_level,
  output logic             tx_below_thr,
  output logic             rx_above_thr,
  output logic             tx_over,
  output logic             rx_under,
  input  logic             abort,
  output logic             eng_req,
  output logic             eng_rd,
  output logic [7:0]       eng_wdata,
  output logic             eng_stop,
  output logic             eng_rstart,
  input  logic             eng_ack,
  input  logic [7:0]       eng_rdata,
  output logic             bus_hold
);
  logic             cmd_full, cmd_empty, cmd_push, cmd_pop;
  logic [CMD_W-1:0] cmd_head_raw;
  cmd_word_t        cmd_head;
  logic             rx_full, rx_empty, rx_push, rx_pop;
  logic [7:0]       rx_head;
  logic             wr_drop, rd_drop;

  assign cmd_ready = !cmd_full && !abort;
  assign cmd_push  = cmd_valid && cmd_ready;
  assign wr_drop   = cmd_valid && cmd_full && !abort;
  assign cmd_head  = cmd_word_t'(cmd_head_raw);

  assign rx_valid  = !rx_empty;
  assign rx_data   = rx_empty ? 8'h00 : rx_head;
  assign rx_pop    = rx_ready && !rx_empty && !abort;
  assign rd_drop   = rx_ready && rx_empty && !abort;

  i2cseq_fifo #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) u_cmd_fifo (
    .clk, .rst_n, .flush(abort),
    .wr_en(cmd_push), .wr_data(cmd_data),
    .rd_en(cmd_pop),  .rd_data(cmd_head_raw),
    .level(tx_level), .full(cmd_full), .empty(cmd_empty)
  );

  i2cseq_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk, .rst_n, .flush(abort),
    .wr_en(rx_push), .wr_data(eng_rdata),
    .rd_en(rx_pop),  .rd_data(rx_head),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  i2cseq_issue u_issue (
    .clk, .rst_n, .abort,
    .cmd_head, .cmd_empty, .cmd_pop,
    .rx_full, .rx_push,
    .eng_req, .eng_rd, .eng_wdata, .eng_stop, .eng_rstart, .eng_ack,
    .bus_hold
  );

  i2cseq_flags #(.TX_LW(TX_LW), .RX_LW(RX_LW)) u_flags (
    .clk, .rst_n,
    .tx_level, .tx_thresh, .rx_level, .rx_thresh,
    .wr_drop, .rd_drop,
    .tx_below_thr, .rx_above_thr, .tx_over, .rx_under
  );

  // Abort empties both FIFOs and cancels the request (R11).
  p_abort_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (tx_level == '0) && (rx_level == '0) && !eng_req);
  // A refused word is reported on the next cycle (R9).
  p_drop_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !abort |=> tx_over);
  // A read of an empty receive FIFO is reported (R10).
  p_under_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && !rx_valid && !abort |=> rx_under);
endmodule

// File: tb/test_i2cseq_top.sv
`timescale 1ns/1ps
module test_i2cseq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [10:0] cmd_data = '0;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic [3:0] tx_thresh = 4'd4;
  logic [3:0] rx_thresh = 4'd0;
  logic [3:0] tx_level, rx_level;
  logic       tx_below_thr, rx_above_thr, tx_over, rx_under;
  logic       abort = 1'b0;
  logic       eng_req, eng_rd, eng_stop, eng_rstart;
  logic [7:0] eng_wdata;
  logic       eng_ack = 1'b0;
  logic [7:0] eng_rdata = '0;
  logic       bus_hold;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  i2cseq_top i_i2cseq_top (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_data,
    .rx_valid, .rx_ready, .rx_data, .tx_thresh, .rx_thresh,
    .tx_level, .rx_level, .tx_below_thr, .rx_above_thr, .tx_over, .rx_under,
    .abort, .eng_req, .eng_rd, .eng_wdata, .eng_stop, .eng_rstart,
    .eng_ack, .eng_rdata, .bus_hold
  );

  // {word[10:0], resp[7:0], exp_rd, exp_wdata[7:0], exp_stop, exp_rstart}
  localparam logic [29:0] VEC [6] = '{
    {11'h0A5, 8'h00, 1'b0, 8'hA5, 1'b0, 1'b0},
    {11'h13C, 8'h5E, 1'b1, 8'h00, 1'b0, 1'b0},
    {11'h4C3, 8'h00, 1'b0, 8'hC3, 1'b0, 1'b1},
    {11'h500, 8'h91, 1'b1, 8'h00, 1'b0, 1'b1},
    {11'h2FF, 8'h00, 1'b0, 8'hFF, 1'b1, 1'b0},
    {11'h377, 8'h42, 1'b1, 8'h00, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Ends at the falling edge after the capturing edge.
  task automatic push(input logic [10:0] w);
    cmd_valid = 1'b1; cmd_data = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ack(input logic [7:0] d);
    eng_ack = 1'b1; eng_rdata = d;
    @(negedge clk);
    eng_ack = 1'b0;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp);
    chk(req, {31'd0, rx_valid}, 32'd1);
    chk(req, {24'd0, rx_data}, {24'd0, exp});
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int rxcnt;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // Reset state
    chk("R6 reset tx_level", {28'd0, tx_level}, 0);
    chk("R6 reset rx_level", {28'd0, rx_level}, 0);
    chk("R12 reset no request", {31'd0, eng_req}, 0);
    chk("R12 reset bus_hold", {31'd0, bus_hold}, 0);
    chk("R7 reset tx_below_thr", {31'd0, tx_below_thr}, 1);
    chk("R8 reset rx_above_thr", {31'd0, rx_above_thr}, 0);
    chk("R1 reset cmd_ready", {31'd0, cmd_ready}, 1);
    chk("R10 reset rx_valid", {31'd0, rx_valid}, 0);

    // Vector table
    rxcnt = 0;
    for (int i = 0; i < 6; i++) begin
      push(VEC[i][29:19]);
      chk("R6 level after write", {28'd0, tx_level}, 1);
      tick();  // launch edge
      chk("R1 request raised", {31'd0, eng_req}, 1);
      chk("R3 eng_rd", {31'd0, eng_rd}, {31'd0, VEC[i][10]});
      chk("R2 eng_wdata", {24'd0, eng_wdata}, {24'd0, VEC[i][9:2]});
      chk("R4 eng_stop", {31'd0, eng_stop}, {31'd0, VEC[i][1]});
      chk("R5 eng_rstart", {31'd0, eng_rstart}, {31'd0, VEC[i][0]});
      ack(VEC[i][18:11]);
      if (VEC[i][10]) rxcnt++;
      chk("R3 rx_level after ack", {28'd0, rx_level}, rxcnt);
      chk("R8 rx_above_thr", {31'd0, rx_above_thr}, {31'd0, rxcnt > 0});
      chk("R12 R4 bus_hold after byte", {31'd0, bus_hold}, {31'd0, !VEC[i][1]});
      chk("R12 no request when empty", {31'd0, eng_req}, 0);
    end

    // Receive order, then empty read
    pop_chk("R14 first byte", 8'h5E);
    pop_chk("R14 second byte", 8'h91);
    pop_chk("R14 third byte", 8'h42);
    chk("R10 empty rx_valid", {31'd0, rx_valid}, 0);
    chk("R10 empty rx_data", {24'd0, rx_data}, 0);
    rx_ready = 1'b1;
    tick();
    rx_ready = 1'b0;
    chk("R10 rx_under pulse", {31'd0, rx_under}, 1);
    chk("R10 level stays 0", {28'd0, rx_level}, 0);
    tick();
    chk("R10 rx_under one cycle", {31'd0, rx_under}, 0);

    // Two bytes received, then fill the command FIFO behind a stalled engine
    push(11'h100); tick(); ack(8'h11);
    push(11'h100); tick(); ack(8'h22);
    chk("R6 rx_level two", {28'd0, rx_level}, 2);
    tx_thresh = 4'd2;
    push(11'h011); tick();
    chk("R2 stalled request", {24'd0, eng_wdata}, 32'h11);
    for (int k = 1; k <= 8; k++) begin
      push(11'h020 + 11'(k));
      chk("R6 tx_level fill", {28'd0, tx_level}, k);
      chk("R7 tx_below_thr fill", {31'd0, tx_below_thr}, {31'd0, k <= 2});
    end
    chk("R9 cmd_ready low when full", {31'd0, cmd_ready}, 0);
    push(11'h0EE);
    chk("R9 tx_over pulse", {31'd0, tx_over}, 1);
    chk("R9 level unchanged", {28'd0, tx_level}, 8);
    tick();
    chk("R9 tx_over one cycle", {31'd0, tx_over}, 0);
    chk("R2 request held", {24'd0, eng_wdata}, 32'h11);
    chk("R2 request still up", {31'd0, eng_req}, 1);

    // Abort
    abort = 1'b1; tick(); abort = 1'b0;
    chk("R11 tx flushed", {28'd0, tx_level}, 0);
    chk("R11 rx flushed", {28'd0, rx_level}, 0);
    chk("R11 request withdrawn", {31'd0, eng_req}, 0);
    chk("R11 bus released", {31'd0, bus_hold}, 0);
    ack(8'h99);
    chk("R11 late ack ignored", {28'd0, rx_level}, 0);
    tick();
    chk("R11 no request after abort", {31'd0, eng_req}, 0);

    // Receive FIFO back-pressure
    rx_thresh = 4'd3;
    for (int k = 0; k < 8; k++) begin
      push(11'h100); tick(); ack(8'hB0 + 8'(k));
      chk("R8 rx_above_thr level", {31'd0, rx_above_thr}, {31'd0, (k + 1) > 3});
    end
    chk("R6 rx full level", {28'd0, rx_level}, 8);
    push(11'h300);
    tick(); tick();
    chk("R13 read held while full", {31'd0, eng_req}, 0);
    chk("R13 word waits in FIFO", {28'd0, tx_level}, 1);
    pop_chk("R14 oldest after fill", 8'hB0);
    tick();
    chk("R13 read issued after room", {31'd0, eng_req}, 1);
    chk("R13 read stop flag", {31'd0, eng_stop}, 1);
    ack(8'hC7);
    chk("R3 rx refilled", {28'd0, rx_level}, 8);
    chk("R4 bus released at end", {31'd0, bus_hold}, 0);

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule